// File: doc/BRIEF.md
# Dual-Range Prescaled Watchdog Timer

This block is a watchdog countdown held inside a small bank of byte-wide registers. The timer counts a programmed number of timebase units and then raises a sticky timeout flag. A 5-bit timeout field sets that number. A prescaler bit picks one of two unit lengths that lie far apart: a short one and a long one. Each unit length is a parameter given in clock cycles.

Software restarts the countdown in one of two ways: it rewrites the watchdog register, or it pulses the kick input. The timeout flag can be read and is also driven on a port. It stays set until software writes a 1 to clear it.

The same register bank also carries the choice of operating-frequency code. The block captures a 5-bit code from external pins once, on the first clock after reset. A software register holds an alternative 5-bit code. An override bit selects which of the two codes drives the registered `freq_code` output.

Top module: `wdt_prescaled`

## Requirements
- R1: After synchronous reset, address 0 reads 0x3E, address 1 reads 0x00, address 2 reads 0x00, `to_status` is 0, `freq_code` is 0, and the countdown restarts with N=31 on the short unit.
- R2: Address 0 holds the watchdog register. Bit 6 is the frequency override, bits 5:1 are the timeout value N, and bit 0 is the prescaler select. Bit 7 reads 0 and writes to it are ignored.
- R3: With prescaler select 0, the timeout flag rises (N+1)*SHORT_TICK clock edges after the edge that reloads the countdown, and no earlier.
- R4: With prescaler select 1, the unit is LONG_TICK cycles, so the flag rises (N+1)*LONG_TICK edges after the reload.
- R5: The timeout flag appears both as `to_status` and as address 1 bit 0. Once set, it stays set. Writing 1 to address 1 bit 0 clears it. Writing 0 to that bit has no effect. An expiry on the same edge as a clear leaves the flag set.
- R6: A write to address 0 or a kick pulse reloads the countdown with the current N and restarts the unit timebase. The full (N+1)-unit period is then measured from that edge.
- R7: After it expires, the countdown halts. A flag cleared afterwards stays clear until a new reload and a new full period have passed.
- R8: The `fs_pins` value is captured into address 3 bits 4:0 on the first clock edge after reset. Later pin changes do not alter it, and writes to address 3 are ignored.
- R9: `freq_code` is registered. One edge after the state changes, it equals address 2 bits 4:0 when the override bit is 1, and the captured pin value when the override bit is 0.
- R10: The reserved bits read 0: address 1 bits 7:1, address 2 bits 7:5, and address 3 bits 7:5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Register write strobe |
| addr | input | 2 | Register address for read and write |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for `addr` (combinational) |
| kick | input | 1 | Restarts the countdown |
| fs_pins | input | 5 | External frequency code, captured once |
| freq_code | output | 5 | Selected frequency code (registered) |
| to_status | output | 1 | Sticky timeout flag |

## Verification
The bench builds the block with SHORT_TICK=3 and LONG_TICK=20. At those values the shortest timeout is a few cycles, and a full 32-unit long-range timeout is only 640 cycles. Both ranges, their exact expiry edges, a kick in the middle of a period, and the sticky flag after expiry can therefore be covered many times within one short run. A behavioural model counts the remaining cycles as a single integer and compares the flag, the frequency code and the read data on every clock.

// File: rtl/wdt_prescaled.sv
module wdt_prescaled #(
  parameter int SHORT_TICK = 15_000_000,
  parameter int LONG_TICK  = 250_000_000
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       wr_en,
  input  logic [1:0] addr,
  input  logic [7:0] wdata,
  output logic [7:0] rdata,
  input  logic       kick,
  input  logic [4:0] fs_pins,
  output logic [4:0] freq_code,
  output logic       to_status
);
  localparam int MAXT = (LONG_TICK > SHORT_TICK) ? LONG_TICK : SHORT_TICK;
  localparam int PW   = $clog2(MAXT + 1);

  logic [6:0]    ctrl;
  logic [4:0]    sel, pins_q, cnt;
  logic [PW-1:0] pcnt;
  logic          captured, done, status;

  wire wr0    = wr_en && addr == 2'd0;
  wire wr1    = wr_en && addr == 2'd1;
  wire wr2    = wr_en && addr == 2'd2;
  wire reload = wr0 || kick;
  wire [PW-1:0] unit_m1 = ctrl[0] ? PW'(LONG_TICK - 1) : PW'(SHORT_TICK - 1);
  wire tick   = !done && pcnt == unit_m1;
  wire expire = tick && cnt == 5'd0;

  assign to_status = status;

  always_comb begin
    case (addr)
      2'd0:    rdata = {1'b0, ctrl};
      2'd1:    rdata = {7'b0, status};
      2'd2:    rdata = {3'b0, sel};
      default: rdata = {3'b0, pins_q};
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl      <= 7'h3E;
      sel       <= '0;
      pins_q    <= '0;
      captured  <= 1'b0;
      freq_code <= '0;
      cnt       <= 5'h1F;
      pcnt      <= '0;
      done      <= 1'b0;
      status    <= 1'b0;
    end else begin
      if (wr0) ctrl <= wdata[6:0];
      if (wr2) sel  <= wdata[4:0];
      if (!captured) begin
        pins_q   <= fs_pins;
        captured <= 1'b1;
      end
      freq_code <= ctrl[6] ? sel : pins_q;

      if (reload) begin
        cnt  <= wr0 ? wdata[5:1] : ctrl[5:1];
        pcnt <= '0;
        done <= 1'b0;
      end else if (tick) begin
        pcnt <= '0;
        if (cnt == 5'd0) done <= 1'b1;
        else             cnt  <= cnt - 5'd1;
      end else if (!done) begin
        pcnt <= pcnt + 1'b1;
      end

      if (expire && !reload)     status <= 1'b1;
      else if (wr1 && wdata[0])  status <= 1'b0;
    end
  end

  AST_STATUS_STICKY: assert property (@(posedge clk) disable iff (rst)
    status && !(wr1 && wdata[0]) |=> status); // R5
  AST_EXPIRE_FLAGS: assert property (@(posedge clk) disable iff (rst)
    $rose(done) |-> status); // R5
  AST_PINS_FROZEN: assert property (@(posedge clk) disable iff (rst)
    captured |=> $stable(pins_q)); // R8
  AST_KICK_RELOAD: assert property (@(posedge clk) disable iff (rst)
    kick && !wr0 |=> cnt == ctrl[5:1] && pcnt == '0 && !done); // R6
  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (rst)
    !done |-> cnt <= ctrl[5:1]); // R3
  AST_UNIT_BOUND: assert property (@(posedge clk) disable iff (rst)
    pcnt <= unit_m1); // R4
endmodule

// File: tb/sim_wdt_prescaled.sv
`timescale 1ns/1ps
module sim_wdt_prescaled;
  localparam int S = 3;
  localparam int L = 20;

  logic clk = 0, rst = 1, wr_en = 0, kick = 0;
  logic [1:0] addr = 0;
  logic [7:0] wdata = 0;
  logic [4:0] fs_pins = 5'h15;
  logic [7:0] rdata;
  logic [4:0] freq_code;
  logic to_status;

  always #2 clk = ~clk;

  wdt_prescaled #(.SHORT_TICK(S), .LONG_TICK(L)) u0 (
    .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .rdata(rdata), .kick(kick), .fs_pins(fs_pins),
    .freq_code(freq_code), .to_status(to_status));

  int checks = 0, errors = 0, cyc = 0;
  bit started = 0;

  task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  // behavioural reference
  logic [6:0] m_ctrl;
  logic [4:0] m_sel, m_pins, m_freq;
  bit m_cap, m_status, m_run;
  int rem;

  always @(posedge clk) begin
    cyc++;
    if (rst) begin
      m_ctrl = 7'h3E; m_sel = 0; m_pins = 0; m_freq = 0;
      m_cap = 0; m_status = 0; m_run = 1; rem = 32 * S;
      started = 1;
    end else begin
      bit set_now;
      set_now = 0;
      m_freq = m_ctrl[6] ? m_sel : m_pins;
      if (!m_cap) begin m_pins = fs_pins; m_cap = 1; end
      if (wr_en && addr == 0) m_ctrl = wdata[6:0];
      if (wr_en && addr == 2) m_sel = wdata[4:0];
      if ((wr_en && addr == 0) || kick) begin
        rem = (int'(m_ctrl[5:1]) + 1) * (m_ctrl[0] ? L : S);
        m_run = 1;
      end else if (m_run) begin
        rem--;
        if (rem == 0) begin m_run = 0; m_status = 1; set_now = 1; end
      end
      if (wr_en && addr == 1 && wdata[0] && !set_now) m_status = 0;
    end
  end

  function automatic logic [7:0] m_rd(logic [1:0] a);
    case (a)
      2'd0: return {1'b0, m_ctrl};
      2'd1: return {7'b0, m_status};
      2'd2: return {3'b0, m_sel};
      default: return {3'b0, m_pins};
    endcase
  endfunction

  always @(negedge clk) begin
    if (started && !rst) begin
      chk("R5 model status", {7'b0, to_status}, {7'b0, m_status});
      chk("R9 model freq", {3'b0, freq_code}, {3'b0, m_freq});
      chk("R2 model rdata", rdata, m_rd(addr));
    end
    if (cyc > 100000) begin
      errors++;
      $display("FAIL watchdog: actual %0d expected <100000", cyc);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic wr(logic [1:0] a, logic [7:0] d);
    @(posedge clk); #1; wr_en = 1; addr = a; wdata = d;
    @(posedge clk); #1; wr_en = 0;
  endtask

  task automatic do_kick();
    @(posedge clk); #1; kick = 1;
    @(posedge clk); #1; kick = 0;
  endtask

  task automatic rd(logic [1:0] a, logic [7:0] exp, string tag);
    addr = a; #0.5;
    chk(tag, rdata, exp);
  endtask

  task automatic wait_edges(int n);
    for (int i = 0; i < n; i++) @(posedge clk);
    #1;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1; rst = 0;
    rd(0, 8'h3E, "R1 ctrl reset");
    rd(1, 8'h00, "R1 status reset");
    rd(2, 8'h00, "R1 sel reset");
    chk("R1 to_status reset", {7'b0, to_status}, 8'h00);
    @(posedge clk); #1; fs_pins = 5'h0A;
    rd(3, 8'h15, "R8 pins captured");

    wr(0, 8'h04);
    wait_edges(8);
    chk("R3 before expiry", {7'b0, to_status}, 8'h00);
    wait_edges(1);
    chk("R3 at expiry", {7'b0, to_status}, 8'h01);

    wr(1, 8'h00);
    rd(1, 8'h01, "R5 write 0 no effect");
    wr(1, 8'h01);
    rd(1, 8'h00, "R5 clear by 1");
    wait_edges(40);
    chk("R7 halted after expiry", {7'b0, to_status}, 8'h00);

    wr(0, 8'h01);
    wait_edges(L - 1);
    chk("R4 before long expiry", {7'b0, to_status}, 8'h00);
    wait_edges(1);
    chk("R4 at long expiry", {7'b0, to_status}, 8'h01);

    wr(1, 8'h01);
    wr(0, 8'h06);
    wait_edges(7);
    do_kick();
    wait_edges(4 * S - 1);
    chk("R6 no expiry before restarted period", {7'b0, to_status}, 8'h00);
    wait_edges(1);
    chk("R6 expiry after kick", {7'b0, to_status}, 8'h01);

    wr(0, 8'hFF);
    rd(0, 8'h7F, "R2 bit7 ignored");
    wr(1, 8'hFF);
    rd(1, 8'h00, "R10 status reserved");
    wr(2, 8'hFF);
    rd(2, 8'h1F, "R10 sel reserved");
    wr(3, 8'h00);
    rd(3, 8'h15, "R8 addr3 write ignored");

    chk("R9 override selects sel", {3'b0, freq_code}, 8'h1F);
    @(posedge clk); #1; wr_en = 1; addr = 2; wdata = 8'h07;
    @(posedge clk); #1; wr_en = 0;
    chk("R9 freq not yet updated", {3'b0, freq_code}, 8'h1F);
    wait_edges(1);
    chk("R9 freq follows sel", {3'b0, freq_code}, 8'h07);
    wr(0, 8'h3E);
    wait_edges(1);
    chk("R9 freq from pins", {3'b0, freq_code}, 8'h15);

    wait_edges(32 * S + 2);
    chk("R1 default period expiry", {7'b0, to_status}, 8'h01);

    wait_edges(5);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule